// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Next-Line Prefetch

This block is a read-only cache that sits between a soft CPU core and a slow main memory. The core has no address translation, so the request address is physical and feeds the tag compare directly. Nothing in the block depends on which task is running, so lines stay resident across context changes. Each set holds two lines, and a single bit per set picks the victim. A hit answers one clock after the request is accepted.

On a miss, the cache issues one line-sized read to memory and waits for the line to return. It writes the line into a way and forwards the requested word in the same clock. After every demand fill, the cache remembers the next sequential line. The first time the CPU leaves the read strobe low, the cache fetches that line if it is not already resident. Only one memory transaction is in flight at a time. A CPU request that arrives while a prefetch is outstanding waits for it. If the request targets the line being prefetched, it is served straight from the returning data.

The CPU holds `cpu_rd_i` and `cpu_addr_i` until `cpu_ready_o` pulses. It then drops the strobe or presents the next address.

Top module: `pf_cache2w`

## Requirements
- R1: After reset, `cpu_ready_o` and `mem_req_o` are low and every line is invalid, so the first access to any address misses.
- R2: A request that hits is answered with `cpu_ready_o` high one clock after acceptance, with no memory request.
- R3: A miss issues exactly one `mem_req_o` pulse with `mem_addr_o` line aligned (low 4 bits zero). The requested word is returned in the clock after `mem_valid_i` is sampled, which is 13 clocks after acceptance when memory answers 12 clocks after the request.
- R4: Two lines whose addresses share index bits [13:4] but differ in bits [31:14] can both be resident and both hit.
- R5: When a set is full, a miss replaces the way that was least recently hit or filled.
- R6: After a demand fill of line N, the cache issues a request for line N+1 in the first idle clock if that line is absent. A later read of that line hits in one clock.
- R7: No prefetch request is issued when line N+1 is already resident.
- R8: A request to the line currently being prefetched is answered in the clock after that fill arrives, with no second memory request.
- R9: A miss to another line during a prefetch issues its own request only after the prefetch data has returned.
- R10: Word k of a line is `mem_line_i[32k+31:32k]`, selected by address bits [3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_rd_i | input | 1 | Read strobe, held until ready |
| cpu_addr_i | input | 32 | Byte address of the requested word |
| cpu_ready_o | output | 1 | One-clock pulse, data valid |
| cpu_data_o | output | 32 | Requested word |
| mem_req_o | output | 1 | One-clock line read request |
| mem_addr_o | output | 32 | Line-aligned memory address |
| mem_line_i | input | 128 | Returned line, word 0 in the low bits |
| mem_valid_i | input | 1 | Line data valid for one clock |

## Verification
A prefetch fill returning from memory can coincide with a stalled CPU request to the same line. In that clock the array write, the victim choice and the forwarded answer all happen together. The bench provokes this by leaving one idle clock after a demand miss, so the prefetch launches, and then requesting the next line at once. It judges the result by the latency (12 clocks), the returned word, and exactly one memory request. A variant with a request to an unrelated line in the same window checks that the demand miss waits for the prefetch to land and then costs 25 clocks in total.

// File: rtl/pf_cache_pkg.sv
package pf_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEM  = 2'd1,
    ST_PRE  = 2'd2
  } cache_st_e;
endpackage

// File: rtl/pf_cache_way.sv
module pf_cache_way #(
  parameter int SETS   = 1024,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 18,
  parameter int LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              we_i,
  input  logic [LINE_W-1:0] wline_i,
  output logic              vld_o,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o
);
  logic              vld_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= 1'b0;
    end else if (we_i) begin
      vld_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[idx_i]  <= tag_i;
      line_q[idx_i] <= wline_i;
    end
  end

  assign vld_o  = vld_q[idx_i];
  assign hit_o  = vld_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign line_o = line_q[idx_i];
endmodule

// File: rtl/pf_cache_lru.sv
module pf_cache_lru #(
  parameter int SETS  = 1024,
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             we_i,
  input  logic             val_i,
  output logic             vict_o
);
  logic bit_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) bit_q[s] <= 1'b0;
    end else if (we_i) begin
      bit_q[idx_i] <= val_i;
    end
  end

  assign vict_o = bit_q[idx_i];
endmodule

// File: rtl/pf_cache2w.sv
module pf_cache2w #(
  parameter int CAP_BYTES  = 32768,
  parameter int LINE_BYTES = 16,
  parameter int AW         = 32,
  parameter int DW         = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpu_rd_i,
  input  logic [AW-1:0]           cpu_addr_i,
  output logic                    cpu_ready_o,
  output logic [DW-1:0]           cpu_data_o,
  output logic                    mem_req_o,
  output logic [AW-1:0]           mem_addr_o,
  input  logic [LINE_BYTES*8-1:0] mem_line_i,
  input  logic                    mem_valid_i
);
  import pf_cache_pkg::*;

  localparam int WAYS   = 2;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WB     = $clog2(DW / 8);
  localparam int WSEL_W = OFF_W - WB;
  localparam int SETS   = CAP_BYTES / (LINE_BYTES * WAYS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LN_W   = AW - OFF_W;
  localparam int TAG_W  = LN_W - IDX_W;

  cache_st_e         st_q;
  logic [LN_W-1:0]   out_line_q, pf_line_q, cpu_line, look_line;
  logic              pf_pend_q, ready_q, req_q;
  logic [WSEL_W-1:0] wsel_q, cpu_wsel;
  logic [DW-1:0]     data_q;

  logic [WAYS-1:0]   way_hit, way_vld;
  logic [LINE_W-1:0] way_line [WAYS];
  logic              hit_any, hit_way, lru_vict, vict, fill_we, lru_we, lru_val;
  logic              is_idle, accept;
  logic [LINE_W-1:0] hit_line;
  logic              unused_lsb;

  assign cpu_line   = cpu_addr_i[AW-1:OFF_W];
  assign cpu_wsel   = cpu_addr_i[OFF_W-1:WB];
  assign unused_lsb = ^cpu_addr_i[WB-1:0];
  assign is_idle    = (st_q == ST_IDLE);
  assign accept     = is_idle && cpu_rd_i;

  // Lookup port: outstanding line while busy, CPU first when idle, else prefetch probe
  always_comb begin
    if (!is_idle)      look_line = out_line_q;
    else if (cpu_rd_i) look_line = cpu_line;
    else               look_line = pf_line_q;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    pf_cache_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_way (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .idx_i   (look_line[IDX_W-1:0]),
      .tag_i   (look_line[LN_W-1:IDX_W]),
      .we_i    (fill_we && (vict == 1'(w))),
      .wline_i (mem_line_i),
      .vld_o   (way_vld[w]),
      .hit_o   (way_hit[w]),
      .line_o  (way_line[w])
    );
  end

  pf_cache_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (look_line[IDX_W-1:0]),
    .we_i   (lru_we),
    .val_i  (lru_val),
    .vict_o (lru_vict)
  );

  assign hit_any  = |way_hit;
  assign hit_way  = way_hit[1];
  assign hit_line = hit_way ? way_line[1] : way_line[0];
  assign fill_we  = !is_idle && mem_valid_i;
  // Empty way first, otherwise the way not touched last
  assign vict     = !way_vld[0] ? 1'b0 : (!way_vld[1] ? 1'b1 : lru_vict);
  assign lru_we   = fill_we || (accept && hit_any);
  assign lru_val  = fill_we ? ~vict : ~hit_way;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      out_line_q <= '0;
      pf_line_q  <= '0;
      pf_pend_q  <= 1'b0;
      wsel_q     <= '0;
      ready_q    <= 1'b0;
      req_q      <= 1'b0;
      data_q     <= '0;
    end else begin
      ready_q <= 1'b0;
      req_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cpu_rd_i) begin
            if (hit_any) begin
              ready_q <= 1'b1;
              data_q  <= hit_line[int'(cpu_wsel)*DW +: DW];
            end else begin
              req_q      <= 1'b1;
              out_line_q <= cpu_line;
              wsel_q     <= cpu_wsel;
              st_q       <= ST_DEM;
            end
          end else if (pf_pend_q) begin
            pf_pend_q <= 1'b0;
            if (!hit_any) begin
              req_q      <= 1'b1;
              out_line_q <= pf_line_q;
              st_q       <= ST_PRE;
            end
          end
        end
        ST_DEM: begin
          if (mem_valid_i) begin
            ready_q   <= 1'b1;
            data_q    <= mem_line_i[int'(wsel_q)*DW +: DW];
            pf_pend_q <= 1'b1;
            pf_line_q <= out_line_q + 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        ST_PRE: begin
          if (mem_valid_i) begin
            // A request stalled on this very line takes the returning data
            if (cpu_rd_i && (cpu_line == out_line_q)) begin
              ready_q <= 1'b1;
              data_q  <= mem_line_i[int'(cpu_wsel)*DW +: DW];
            end
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready_o = ready_q;
  assign cpu_data_o  = data_q;
  assign mem_req_o   = req_q;
  assign mem_addr_o  = {out_line_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/pf_cache_chk.sv
module pf_cache_chk #(
  parameter int AW    = 32,
  parameter int OFF_W = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_rd_i,
  input logic          cpu_ready_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          hit_i,
  input logic          idle_i
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          outst_q <= 1'b0;
    else if (mem_req_o)   outst_q <= 1'b1;
    else if (mem_valid_i) outst_q <= 1'b0;
  end

  p_ready_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> $past(cpu_rd_i));

  p_hit_one_clock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && cpu_rd_i && hit_i) |=> (cpu_ready_o && !mem_req_o));

  p_miss_requests_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && cpu_rd_i && !hit_i) |=> (mem_req_o && !cpu_ready_o));

  p_line_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

  p_single_outstanding_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outst_q);
endmodule

bind pf_cache2w pf_cache_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_rd_i    (cpu_rd_i),
  .cpu_ready_o (cpu_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i),
  .hit_i       (hit_any),
  .idle_i      (is_idle)
);

// File: tb/sim_pf_cache2w.sv
`timescale 1ns/1ps
module sim_pf_cache2w;
  localparam int LAT = 12;
  localparam int NV  = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd = 1'b0;
  logic [31:0]  addr = '0;
  logic         ready;
  logic [31:0]  data;
  logic         mreq;
  logic [31:0]  maddr;
  logic [127:0] mline = '0;
  logic         mvalid = 1'b0;

  int           n_cmp = 0, n_bad = 0, req_cnt = 0, mcnt = 0;
  logic [31:0]  last_maddr = '0, pend_addr = '0;
  logic         fin = 1'b0;

  always #5 clk = ~clk;

  pf_cache2w u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_rd_i(rd), .cpu_addr_i(addr),
    .cpu_ready_o(ready), .cpu_data_o(data), .mem_req_o(mreq),
    .mem_addr_o(maddr), .mem_line_i(mline), .mem_valid_i(mvalid)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    return {a[31:4], a[3:2], 2'b01};
  endfunction

  // Memory model: data valid LAT clocks after the request edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mcnt   <= 0;
      mvalid <= 1'b0;
    end else begin
      mvalid <= 1'b0;
      if (mreq) begin
        req_cnt    <= req_cnt + 1;
        last_maddr <= maddr;
        pend_addr  <= maddr;
        mcnt       <= LAT - 1;
      end else if (mcnt != 0) begin
        if (mcnt == 1) begin
          mvalid <= 1'b1;
          for (int k = 0; k < 4; k++) mline[32*k +: 32] <= {pend_addr[31:4], 2'(k), 2'b01};
        end
        mcnt <= mcnt - 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd_word(input logic [31:0] a, output int lat, output logic [31:0] d);
    bit done = 0;
    @(negedge clk);
    rd = 1'b1; addr = a; lat = 0; d = '0;
    while (!done) begin
      @(posedge clk); #1;
      lat++;
      if (ready) begin done = 1; d = data; end
      if (lat > 200) done = 1;
    end
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // addr, latency, memory requests
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h0000_1000, 32'h0000_1004, 32'h0000_100C, 32'h0000_5000,
    32'h0000_1008, 32'h0000_5000, 32'h0000_1000, 32'h0000_9000,
    32'h0000_1004, 32'h0000_5004, 32'h0000_9000, 32'h0000_2010,
    32'h0000_2010, 32'h0000_5008};
  // R1 R3 first miss; R2 R10 hits; R4 shared set; R5 LRU evictions
  localparam int V_LAT [NV] = '{13, 1, 1, 13, 1, 1, 1, 13, 1, 13, 13, 13, 1, 1};
  localparam int V_REQ [NV] = '{ 1, 0, 0,  1, 0, 0, 0,  1, 0,  1,  1,  1, 0, 0};

  initial begin
    int          lat, r0;
    logic [31:0] d;
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(ready), 0);
    chk("R1 mem_req in reset", int'(mreq), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 ready after reset", int'(ready), 0);

    for (int i = 0; i < NV; i++) begin
      r0 = req_cnt;
      rd_word(V_ADDR[i], lat, d);
      chk($sformatf("R2/R3/R4/R5 vec%0d latency", i), lat, V_LAT[i]);
      chk($sformatf("R10 vec%0d data", i), int'(d), int'(exp_word(V_ADDR[i])));
      chk($sformatf("R3/R5 vec%0d mem requests", i), req_cnt - r0, V_REQ[i]);
    end
    chk("R3 miss address aligned", int'(last_maddr), 32'h0000_2010);

    // R1: contents lost on reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    r0 = req_cnt;
    rd_word(32'h0000_1000, lat, d);
    chk("R1 refetch after reset", lat, 13);
    chk("R1 one request", req_cnt - r0, 1);

    // R6: next line fetched while idle, then hits
    r0 = req_cnt;
    idle(20);
    chk("R6 prefetch issued", req_cnt - r0, 1);
    chk("R6 prefetch address", int'(last_maddr), 32'h0000_1010);
    r0 = req_cnt;
    rd_word(32'h0000_1014, lat, d);
    chk("R6 prefetched hit latency", lat, 1);
    chk("R6 prefetched data", int'(d), int'(exp_word(32'h0000_1014)));
    chk("R6 no request", req_cnt - r0, 0);

    // R7: next line resident, no prefetch
    rd_word(32'h0000_0FF0, lat, d);
    chk("R7 demand miss", lat, 13);
    r0 = req_cnt;
    idle(20);
    chk("R7 no prefetch", req_cnt - r0, 0);

    // R8: request to in-flight prefetch line
    rd_word(32'h0000_3000, lat, d);
    chk("R8 demand miss", lat, 13);
    r0 = req_cnt;
    idle(1);
    rd_word(32'h0000_3018, lat, d);
    chk("R8 forwarded latency", lat, 12);
    chk("R8 forwarded data", int'(d), int'(exp_word(32'h0000_3018)));
    chk("R8 single request", req_cnt - r0, 1);

    // R9: other-line miss waits for prefetch
    rd_word(32'h0000_4000, lat, d);
    chk("R9 demand miss", lat, 13);
    r0 = req_cnt;
    idle(1);
    rd_word(32'h0000_7004, lat, d);
    chk("R9 queued miss latency", lat, 25);
    chk("R9 queued miss data", int'(d), int'(exp_word(32'h0000_7004)));
    chk("R9 two requests", req_cnt - r0, 2);
    chk("R9 last request", int'(last_maddr), 32'h0000_7000);
    rd_word(32'h0000_4010, lat, d);
    chk("R6 earlier prefetch kept", lat, 1);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule